// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Pipeline

This block is a cycle-accurate model of a synchronous burst SRAM core built around a small array. On each rising clock edge it samples an address, three chip enables, two address strobes, a burst-step control, an all-bytes write control, a byte-write control and one write select per byte. From these it classifies the cycle as idle, deselect, read or write. For reads and writes it also picks one of three address sources: the external address, the next burst address, or the current burst address again.

A two-bit burst counter walks a four-word group, either linearly or in interleaved (XOR) order. A static mode input selects how read data reaches the output. In flow-through mode data is presented straight from the array. In pipelined mode it passes through an extra output register. The output data has a separate drive-enable output. An asynchronous active-low output enable can only suppress driving. The data path has no handshake: the host owns the cycle timing and the block never stalls.

Top module: `sburst_sram`

## Requirements
- R1: A cycle that starts on either strobe is accepted only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. Otherwise it is a deselect: `dq_drive` is 0 after that edge and any burst in progress ends.
- R2: With `en_a_n`=1 the host strobe is ignored. If `strb_ctl_n`=0 the cycle is a deselect; if `strb_ctl_n`=1 the cycle is treated as a continue or suspend cycle.
- R3: An accepted host-strobe cycle is always a read of `addr`. The write controls are ignored and the array is left unchanged.
- R4: An accepted controller-strobe cycle (host strobe high or masked) is a write when `wr_all_n`=0, or when `wr_byte_n`=0 with at least one `byte_sel_n` bit at 0. Otherwise it is a read. `wr_all_n`=0 writes every byte. Otherwise only byte k, at bits [9k+8:9k], is written, and only when `byte_sel_n[k]`=0.
- R5: When neither strobe starts a cycle, a burst is active and `step_n`=0, the operation uses the next burst address. With start low bits s and step count k (mod 4), the low two address bits are (s+k) mod 4 when `lin_order`=1 and s XOR k when `lin_order`=0. The upper bits stay fixed, and the group wraps after four addresses.
- R6: The same cycle with `step_n`=1 repeats the current burst address. The read/write choice follows the rule in R4.
- R7: Read latency. When `flow_thru`=1, data for a read captured at edge n is driven after edge n. When `flow_thru`=0, it is driven after edge n+1.
- R8: `dq_drive` is 0 after any edge that captured a write, whatever the byte selects are.
- R9: Turn-off takes a single cycle. In pipelined mode, data is driven after edge n+1 only if the operation captured at edge n+1 is also a read. A read followed by a deselect or a write is never driven.
- R10: `oe_n`=1 forces `dq_drive` to 0 at once, without waiting for a clock. `oe_n`=0 enables driving only when R7 and R9 provide valid data.
- R11: A read issued with `oe_n`=1 still advances the burst exactly like a visible read.
- R12: A continue or suspend cycle with no active burst (after reset or a deselect) does nothing: no write and no drive.
- R13: During and after reset `dq_drive` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_thru | input | 1 | 1 = flow-through reads, 0 = pipelined reads (static) |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | External word address |
| en_a_n | input | 1 | Chip enable, active low; also masks the host strobe |
| en_b | input | 1 | Chip enable, active high, sampled only with a strobe |
| en_c_n | input | 1 | Chip enable, active low, sampled only with a strobe |
| strb_host_n | input | 1 | Host address strobe, active low, always starts a read |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step: 0 = next address, 1 = repeat |
| wr_all_n | input | 1 | Write every byte, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| byte_sel_n | input | NB | Per-byte write select, active low |
| wdata | input | NB*9 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | NB*9 | Read data, zero when not driven |
| dq_drive | output | 1 | Output driver enable |

## Verification
The bench goes after the corner cases where one rule overrides another. The first is the host strobe carrying active write controls: a design that honoured them would corrupt the array. The second is the host strobe being masked by `en_a_n` and turning into a continue cycle: a wrong design would deselect or reload the address instead. A pipelined read followed by a deselect or a write must stay undriven; a design with two-cycle turn-off would drive stale data onto the bus. Burst sequences in both orders, run past the four-word wrap and mixed with suspends and hidden (output-disabled) reads, would expose a counter that steps in the wrong order, fails to wrap, or freezes while outputs are disabled. Continue cycles issued with no active burst would expose a design that writes at a stale address.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  timeunit 1ns; timeprecision 100ps;

  // Operation captured at a clock edge.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_DESEL = 2'd1,
    OP_RD    = 2'd2,
    OP_WR    = 2'd3
  } op_e;

  // Address source for the cycle.
  typedef enum logic [1:0] {
    ADR_HOLD = 2'd0,
    ADR_STEP = 2'd1,
    ADR_LOAD = 2'd2
  } adr_e;

  localparam int BYTE_BITS = 9;

  // Low two address bits for step count k from start bits s.
  function automatic logic [1:0] burst_low(input logic lin,
                                           input logic [1:0] s,
                                           input logic [1:0] k);
    logic [1:0] sum;
    sum = s + k;
    return lin ? sum : (s ^ k);
  endfunction
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          strb_host_n,
  input  logic          strb_ctl_n,
  input  logic          en_a_n,
  input  logic          en_b,
  input  logic          en_c_n,
  input  logic          step_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NB-1:0] byte_sel_n,
  input  logic          burst_on,
  output op_e           op,
  output adr_e          adr_sel,
  output logic [NB-1:0] wr_mask
);
  timeunit 1ns; timeprecision 100ps;

  logic host_go;
  logic chip_on;
  logic wr_hit;

  // Host strobe counts only while the first enable is active.
  assign host_go = !strb_host_n && !en_a_n;
  assign chip_on = !en_a_n && en_b && !en_c_n;
  assign wr_hit  = !wr_all_n || (!wr_byte_n && !(&byte_sel_n));

  always_comb begin
    op      = OP_IDLE;
    adr_sel = ADR_HOLD;
    if (host_go) begin
      op      = chip_on ? OP_RD : OP_DESEL;
      adr_sel = chip_on ? ADR_LOAD : ADR_HOLD;
    end else if (!strb_ctl_n) begin
      if (chip_on) begin
        op      = wr_hit ? OP_WR : OP_RD;
        adr_sel = ADR_LOAD;
      end else begin
        op      = OP_DESEL;
      end
    end else if (burst_on) begin
      op      = wr_hit ? OP_WR : OP_RD;
      adr_sel = step_n ? ADR_HOLD : ADR_STEP;
    end
  end

  always_comb begin
    if (!wr_all_n)       wr_mask = '1;
    else if (!wr_byte_n) wr_mask = ~byte_sel_n;
    else                 wr_mask = '0;
  end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  adr_e          adr_sel,
  input  logic          lin_order,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] eff_addr
);
  timeunit 1ns; timeprecision 100ps;

  localparam int HI_W = AW - 2;

  logic [AW-1:0]   base_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_nx;
  logic [HI_W-1:0] hi_bits;

  assign hi_bits = base_q[AW-1:2];

  always_comb begin
    cnt_nx   = cnt_q;
    eff_addr = {hi_bits, burst_low(lin_order, base_q[1:0], cnt_q)};
    unique case (adr_sel)
      ADR_LOAD: begin
        cnt_nx   = '0;
        eff_addr = ext_addr;
      end
      ADR_STEP: begin
        cnt_nx   = cnt_q + 2'd1;
        eff_addr = {hi_bits, burst_low(lin_order, base_q[1:0], cnt_nx)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_nx;
      if (adr_sel == ADR_LOAD) base_q <= ext_addr;
    end
  end

  // R5: a step moves the count on by exactly one.
  a_r5_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_sel == ADR_STEP) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  // R5: a load restarts the group at the external address.
  a_r5_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_sel == ADR_LOAD) |=> (cnt_q == 2'd0 && base_q == $past(ext_addr)));

  // R6: a hold leaves the burst state untouched.
  a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_sel == ADR_HOLD) |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int NB     = 4,
  parameter int BYTE_W = 9,
  parameter int AW     = 6
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [NB-1:0]        wr_mask,
  input  logic [AW-1:0]        wr_addr,
  input  logic [NB*BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [NB*BYTE_W-1:0] rd_data
);
  timeunit 1ns; timeprecision 100ps;

  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[b]) lane_q[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = lane_q[rd_addr];
  end
endmodule

// File: rtl/sbs_read_out.sv
module sbs_read_out #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flow_thru,
  input  logic         oe_n,
  input  logic         rd_now,
  input  logic [W-1:0] arr_data,
  output logic [W-1:0] dq_out,
  output logic         dq_drive
);
  timeunit 1ns; timeprecision 100ps;

  logic         prev_rd_q;
  logic [W-1:0] pipe_q;
  logic         valid;
  logic [W-1:0] src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd_q <= 1'b0;
      pipe_q    <= '0;
    end else begin
      prev_rd_q <= rd_now;
      if (rd_now) pipe_q <= arr_data;
    end
  end

  // A deselect or write in the current slot cancels pipelined data.
  assign valid    = flow_thru ? rd_now : (prev_rd_q && rd_now);
  assign src      = flow_thru ? arr_data : pipe_q;
  assign dq_drive = valid && !oe_n;
  assign dq_out   = dq_drive ? src : '0;

  // R10: output enable high always silences the bus.
  a_r10_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);

  // R7: pipelined data needs a read one edge earlier.
  a_r7_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && dq_drive) |-> $past(rd_now));
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sbs_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_thru,
  input  logic                    lin_order,
  input  logic [AW-1:0]           addr,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic                    strb_host_n,
  input  logic                    strb_ctl_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [NB-1:0]           byte_sel_n,
  input  logic [NB*BYTE_BITS-1:0] wdata,
  input  logic                    oe_n,
  output logic [NB*BYTE_BITS-1:0] dq_out,
  output logic                    dq_drive
);
  timeunit 1ns; timeprecision 100ps;

  localparam int W = NB * BYTE_BITS;

  op_e           op;
  adr_e          adr_sel;
  logic [NB-1:0] wr_mask;
  logic [AW-1:0] eff_addr;
  logic [W-1:0]  arr_data;
  op_e           cur_op_q;
  logic [AW-1:0] rd_addr_q;
  logic          active_q;
  logic          chip_on_in;

  sbs_cmd_decode #(.NB(NB)) u_dec (
    .strb_host_n (strb_host_n),
    .strb_ctl_n  (strb_ctl_n),
    .en_a_n      (en_a_n),
    .en_b        (en_b),
    .en_c_n      (en_c_n),
    .step_n      (step_n),
    .wr_all_n    (wr_all_n),
    .wr_byte_n   (wr_byte_n),
    .byte_sel_n  (byte_sel_n),
    .burst_on    (active_q),
    .op          (op),
    .adr_sel     (adr_sel),
    .wr_mask     (wr_mask)
  );

  sbs_burst_addr #(.AW(AW)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .adr_sel   (adr_sel),
    .lin_order (lin_order),
    .ext_addr  (addr),
    .eff_addr  (eff_addr)
  );

  sbs_array #(.NB(NB), .BYTE_W(BYTE_BITS), .AW(AW)) u_arr (
    .clk     (clk),
    .wr_en   (op == OP_WR),
    .wr_mask (wr_mask),
    .wr_addr (eff_addr),
    .wr_data (wdata),
    .rd_addr (rd_addr_q),
    .rd_data (arr_data)
  );

  // Command stage: operation and address captured at each edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_op_q  <= OP_IDLE;
      rd_addr_q <= '0;
      active_q  <= 1'b0;
    end else begin
      cur_op_q  <= op;
      rd_addr_q <= eff_addr;
      if (adr_sel == ADR_LOAD) active_q <= 1'b1;
      else if (op == OP_DESEL) active_q <= 1'b0;
    end
  end

  sbs_read_out #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_thru (flow_thru),
    .oe_n      (oe_n),
    .rd_now    (cur_op_q == OP_RD),
    .arr_data  (arr_data),
    .dq_out    (dq_out),
    .dq_drive  (dq_drive)
  );

  assign chip_on_in = !en_a_n && en_b && !en_c_n;

  // R1: a strobe without all enables is a deselect.
  a_r1_gate_desel: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_host_n || en_a_n) && !strb_ctl_n && !chip_on_in)
      |=> (cur_op_q == OP_DESEL && !dq_drive));

  // R3: an accepted host strobe always reads.
  a_r3_host_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_host_n && chip_on_in) |=> (cur_op_q == OP_RD));

  // R8: no drive after a captured write.
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op_q == OP_WR) |-> !dq_drive);

  // R9: no drive after a captured deselect.
  a_r9_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op_q == OP_DESEL) |-> !dq_drive);

  // R12: no operation without an active burst.
  a_r12_idle_inert: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_host_n || en_a_n) && strb_ctl_n && !active_q)
      |=> (cur_op_q == OP_IDLE && !dq_drive));
endmodule

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb;
  timeunit 1ns; timeprecision 100ps;

  localparam int NB    = 4;
  localparam int AW    = 6;
  localparam int W     = NB * 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic flow_thru, lin_order;
  logic [AW-1:0] addr;
  logic en_a_n, en_b, en_c_n, strb_host_n, strb_ctl_n, step_n;
  logic wr_all_n, wr_byte_n, oe_n;
  logic [NB-1:0] byte_sel_n;
  logic [W-1:0] wdata;
  logic [W-1:0] dq_out;
  logic dq_drive;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // Reference state
  logic [W-1:0]  m_mem [DEPTH];
  logic          m_active, m_cur_rd, m_prev_rd;
  logic [AW-1:0] m_base, m_cur_addr;
  logic [1:0]    m_cnt;
  logic [W-1:0]  m_pipe;

  always #5 clk = ~clk;

  sburst_sram #(.NB(NB), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .lin_order(lin_order),
    .addr(addr), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
    .wdata(wdata), .oe_n(oe_n), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  function automatic logic [AW-1:0] grp_addr(input logic [AW-1:0] b, input logic [1:0] k);
    logic [1:0] lo;
    lo = lin_order ? 2'(b[1:0] + k) : (b[1:0] ^ k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference step for one edge, from the requirements.
  task automatic model_edge();
    logic chip, wr, host, go;
    logic [AW-1:0] a;
    int kind; // 0 idle, 1 deselect, 2 read, 3 write
    m_prev_rd = m_cur_rd;
    if (m_cur_rd) m_pipe = m_mem[m_cur_addr];
    chip = !en_a_n && en_b && !en_c_n;
    wr   = !wr_all_n || (!wr_byte_n && (byte_sel_n != '1));
    host = !strb_host_n && !en_a_n;
    go   = 1'b0;
    kind = 0;
    a    = grp_addr(m_base, m_cnt);
    if (host || !strb_ctl_n) begin
      if (chip) begin
        kind = (host || !wr) ? 2 : 3;
        m_base = addr; m_cnt = 2'd0; m_active = 1'b1; a = addr; go = 1'b1;
      end else begin
        kind = 1; m_active = 1'b0;
      end
    end
    if (!go && kind == 0 && m_active) begin
      kind = wr ? 3 : 2;
      if (!step_n) m_cnt = m_cnt + 2'd1;
      a = grp_addr(m_base, m_cnt);
    end
    if (kind == 3)
      for (int b = 0; b < NB; b++)
        if (!wr_all_n || !byte_sel_n[b]) m_mem[a][b*9 +: 9] = wdata[b*9 +: 9];
    m_cur_rd   = (kind == 2);
    m_cur_addr = a;
  endtask

  task automatic tick(input string tag);
    logic exp_drv;
    logic [W-1:0] exp_dat;
    model_edge();
    @(posedge clk); #2;
    exp_drv = (flow_thru ? m_cur_rd : (m_prev_rd && m_cur_rd)) && !oe_n;
    exp_dat = flow_thru ? m_mem[m_cur_addr] : m_pipe;
    chk({tag, " drive"}, W'(dq_drive), W'(exp_drv));
    if (exp_drv) begin
      chk({tag, " data"}, dq_out, exp_dat);
      oe_n = 1'b1; #1;
      chk({tag, " R10 async off"}, W'(dq_drive), '0);
      oe_n = 1'b0; #1;
    end
  endtask

  task automatic in_rest();
    strb_host_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = '1;
    en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0; oe_n = 1'b0;
    wdata = W'({$urandom(), $urandom()});
  endtask

  task automatic go_ctl(input logic [AW-1:0] a, input logic wr, input string tag);
    in_rest(); strb_ctl_n = 1'b0; addr = a; wr_all_n = !wr; tick(tag);
  endtask

  task automatic go_cont(input logic stp, input logic wr, input string tag);
    in_rest(); step_n = !stp; wr_all_n = !wr; tick(tag);
  endtask

  task automatic go_desel(input string tag);
    in_rest(); en_a_n = 1'b1; strb_ctl_n = 1'b0; tick(tag);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; flow_thru = 1'b1; lin_order = 1'b1; addr = '0;
    in_rest();
    m_active = 1'b0; m_cur_rd = 1'b0; m_prev_rd = 1'b0;
    m_base = '0; m_cnt = '0; m_cur_addr = '0; m_pipe = '0;
    repeat (3) @(posedge clk);
    #2 chk("R13 reset drive", W'(dq_drive), '0);
    rst_n = 1'b1;
    go_cont(1'b1, 1'b1, "R13 no burst after reset");

    // Fill the array with known words.
    for (int i = 0; i < DEPTH; i++) go_ctl(AW'(i), 1'b1, "R4 fill write");

    go_ctl(AW'(5), 1'b0, "R7 flow read");
    in_rest(); strb_ctl_n = 1'b0; addr = AW'(6); en_b = 1'b0; tick("R1 second enable off");
    in_rest(); strb_host_n = 1'b0; addr = AW'(7); en_c_n = 1'b1; tick("R1 third enable off");
    go_ctl(AW'(8), 1'b0, "R2 setup read");
    in_rest(); strb_host_n = 1'b0; en_a_n = 1'b1; step_n = 1'b0; tick("R2 masked host continues");
    in_rest(); strb_host_n = 1'b0; en_a_n = 1'b1; strb_ctl_n = 1'b0; tick("R2 masked with ctl deselects");
    in_rest(); strb_host_n = 1'b0; addr = AW'(12); wr_all_n = 1'b0; wr_byte_n = 1'b0; byte_sel_n = '0;
    tick("R3 host ignores writes");
    go_ctl(AW'(12), 1'b0, "R3 array unchanged");
    in_rest(); strb_ctl_n = 1'b0; addr = AW'(20); wr_byte_n = 1'b0; byte_sel_n = 4'b1010;
    tick("R4 partial byte write");
    go_ctl(AW'(20), 1'b0, "R4 partial readback");
    in_rest(); strb_ctl_n = 1'b0; addr = AW'(21); byte_sel_n = 4'b0000; tick("R4 selects without qualifier read");
    go_ctl(AW'(22), 1'b0, "R5 linear start");
    for (int i = 0; i < 5; i++) go_cont(1'b1, 1'b0, "R5 linear step");
    for (int i = 0; i < 2; i++) go_cont(1'b0, 1'b0, "R6 suspend");
    lin_order = 1'b0;
    go_ctl(AW'(23), 1'b0, "R5 interleaved start");
    for (int i = 0; i < 5; i++) go_cont(1'b1, 1'b0, "R5 interleaved step");
    go_cont(1'b1, 1'b1, "R8 burst write");
    in_rest(); step_n = 1'b0; wr_byte_n = 1'b0; byte_sel_n = 4'b0111; tick("R8 byte write quiet");
    go_desel("R9 deselect");
    go_cont(1'b1, 1'b1, "R12 idle continue");
    go_cont(1'b0, 1'b1, "R12 idle suspend");
    go_ctl(AW'(24), 1'b0, "R12 array intact");
    flow_thru = 1'b0; lin_order = 1'b1;
    in_rest(); strb_ctl_n = 1'b0; addr = AW'(30); oe_n = 1'b1; tick("R11 hidden read start");
    in_rest(); step_n = 1'b0; oe_n = 1'b1; tick("R11 hidden step");
    go_cont(1'b1, 1'b0, "R11 visible after hidden");
    go_cont(1'b1, 1'b0, "R7 pipeline stream");
    go_ctl(AW'(40), 1'b0, "R7 pipeline first");
    go_ctl(AW'(41), 1'b0, "R7 pipeline second");
    go_desel("R9 pipeline read cut by deselect");
    go_ctl(AW'(42), 1'b0, "R9 read before write");
    go_cont(1'b1, 1'b1, "R9 read cut by write");

    // Random phases over both modes and orders.
    for (int ph = 0; ph < 4; ph++) begin
      flow_thru = ph[0]; lin_order = ph[1];
      for (int c = 0; c < 1500; c++) begin
        int k;
        in_rest();
        k = int'($urandom() % 10);
        addr = AW'($urandom());
        en_a_n = ($urandom() % 6 == 0); en_b = ($urandom() % 6 != 0); en_c_n = ($urandom() % 6 == 0);
        if (k < 3) strb_host_n = 1'b0;
        else if (k < 6) strb_ctl_n = 1'b0;
        else if (k == 6) begin strb_host_n = 1'b0; strb_ctl_n = 1'b0; end
        step_n = ($urandom() % 3 == 0);
        wr_all_n = ($urandom() % 4 != 0); wr_byte_n = $urandom() % 2;
        byte_sel_n = NB'($urandom()); oe_n = ($urandom() % 6 == 0);
        tick("R7 R8 R9 random");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule